// File: doc/BRIEF.md
# I2C Slave Write-Only Byte Receiver

This block listens on an I2C bus as a slave with one fixed 7-bit address and accepts only transfers in which the master writes. Both bus lines pass through two-flop synchronizers. START and STOP are recognised while SCL is high. The first byte after a START is shifted in and compared with the block's own address. If it matches and its direction bit asks for a write, the address byte is placed in the receive buffer and acknowledged. The data bytes that follow are then accepted one at a time, and each one is acknowledged.

A host on the same clock sees a single receive buffer and three flags. The first is a per-byte interrupt flag, which stays set until the host clears it. The second is a buffer-full flag, which reading the buffer clears. The third is a sticky overflow flag. If a byte completes while the previous one is still unread, the block does not acknowledge it and discards it. The old buffer contents stay in place, the overflow flag is set, and the block ignores the bus until the next START. The master is expected to end the transfer with a STOP.

Top module: `i2c_byte_rx`

## Requirements
- R1: After reset, sdaDriveLow is 0, rxFull, rxIrq and rxOvf are 0, and rxData is 0.
- R2: The first byte after a START has the address in bits 7..1 and the direction in bit 0, and it arrives MSB first. When bits 7..1 equal SLAVE_ADDR and bit 0 is 0 (write), the byte is acknowledged and the whole address byte is loaded into rxData. rxFull and rxIrq are set.
- R3: An address byte whose bits 7..1 differ from SLAVE_ADDR, or whose bit 0 is 1, is not acknowledged and changes neither rxData nor any flag. Further bytes up to the next START are also not acknowledged and are ignored.
- R4: After an accepted address, each data byte is shifted in MSB first. It is acknowledged, loaded into rxData, and sets rxFull and rxIrq.
- R5: The acknowledge pulls SDA low (sdaDriveLow = 1) from the SCL falling edge after the eighth bit to the SCL falling edge after the ninth clock. sdaDriveLow never changes while SCL is high.
- R6: A byte that completes while rxFull is 1 is not acknowledged. It sets rxOvf and rxIrq, and rxData keeps its old value. Later bytes up to the next START are ignored.
- R7: A one-cycle hostRead clears rxFull but leaves rxOvf unchanged. hostClrOvf clears rxOvf, and hostClrIrq clears rxIrq. Each flag stays set until its clear pulse arrives.
- R8: A repeated START begins a new address phase at once. After a STOP, clocked bytes are ignored until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | 1 pulls SDA low (acknowledge) |
| hostRead | input | 1 | Host buffer-read strobe, clears rxFull |
| hostClrIrq | input | 1 | Host strobe clearing rxIrq |
| hostClrOvf | input | 1 | Host strobe clearing rxOvf |
| rxData | output | 8 | Receive buffer |
| rxFull | output | 1 | Buffer holds an unread byte |
| rxIrq | output | 1 | Per-byte interrupt flag |
| rxOvf | output | 1 | Sticky overflow flag |

## Verification
The bench sends all 256 address byte values. This catches a compare that ignores the direction bit or gets one address bit wrong, because such a design would acknowledge a wrong byte or refuse its own address. All 256 data values are then sent in a single transfer, which exposes a swapped bit order or an off-by-one bit count as a wrong buffer value or a missing acknowledge. An overflow is forced while the address byte is still unread. A design that overwrote the buffer, acknowledged the byte, or let a buffer read clear the overflow flag would show the wrong buffer value, an acknowledge, or a cleared flag. Repeated START, STOP and bytes sent after a refusal test that the block does not remain in, or slip back into, a receiving state.

// File: rtl/i2c_byte_rx_pkg.sv
package i2c_byte_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } rxState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic loadBuf;
    logic setIrq;
    logic setOvf;
  } rxStrobe_t;

endpackage

// File: rtl/i2c_byte_rx_sync.sv
module i2c_byte_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startCond,
  output logic stopCond
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startCond = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopCond  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/i2c_byte_rx_ctrl.sv
module i2c_byte_rx_ctrl
  import i2c_byte_rx_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startCond,
  input  logic      stopCond,
  input  logic      addrHit,
  input  logic      bufFull,
  output rxStrobe_t strb,
  output logic      sdaLow
);

  localparam int CNT_W = $clog2(BYTE_BITS + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);
  localparam logic [CNT_W-1:0] SLOT_END = CNT_W'(BYTE_BITS + 1);

  rxState_t         state;
  logic [CNT_W-1:0] bitCnt;
  logic             ackOn;
  logic             inByte;
  logic             byteDone;
  logic             wanted;
  logic             ackGo;

  assign inByte   = (state == ST_ADDR) || (state == ST_DATA);
  assign byteDone = inByte && sclFall && (bitCnt == LAST_BIT) && !ackOn;
  assign wanted   = (state == ST_DATA) || addrHit;
  assign ackGo    = byteDone && wanted && !bufFull;

  always_comb begin
    strb         = '0;
    strb.shiftIn = inByte && sclRise && (bitCnt < LAST_BIT);
    strb.loadBuf = ackGo;
    strb.setIrq  = byteDone && wanted;
    strb.setOvf  = byteDone && wanted && bufFull;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (startCond) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (stopCond) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
      ackOn  <= 1'b0;
    end else if (inByte) begin
      if (sclRise && bitCnt != SLOT_END) bitCnt <= bitCnt + 1'b1;
      if (byteDone) begin
        ackOn <= ackGo;
        state <= ackGo ? ST_DATA : ST_SKIP;
      end
      if (sclFall && bitCnt == SLOT_END) begin
        ackOn  <= 1'b0;
        bitCnt <= '0;
      end
    end
  end

  assign sdaLow = ackOn;

endmodule

// File: rtl/i2c_byte_rx_dp.sv
module i2c_byte_rx_dp
  import i2c_byte_rx_pkg::*;
#(
  parameter int              DATA_W     = 8,
  parameter int              ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'h2A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdaLvl,
  input  rxStrobe_t         strb,
  input  logic              hostRead,
  input  logic              hostClrIrq,
  input  logic              hostClrOvf,
  output logic              addrHit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              rxIrq,
  output logic              rxOvf
);

  logic [DATA_W-1:0] shReg;

  // address in the upper bits, direction in bit 0 (0 = write)
  assign addrHit = (shReg[DATA_W-1:DATA_W-ADDR_W] == SLAVE_ADDR) && !shReg[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      rxData <= '0;
      rxFull <= 1'b0;
      rxIrq  <= 1'b0;
      rxOvf  <= 1'b0;
    end else begin
      if (strb.shiftIn) shReg <= {shReg[DATA_W-2:0], sdaLvl};
      if (strb.loadBuf) rxData <= shReg;
      if (strb.loadBuf)   rxFull <= 1'b1;
      else if (hostRead)  rxFull <= 1'b0;
      if (strb.setIrq)     rxIrq <= 1'b1;
      else if (hostClrIrq) rxIrq <= 1'b0;
      if (strb.setOvf)     rxOvf <= 1'b1;
      else if (hostClrOvf) rxOvf <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_byte_rx.sv
module i2c_byte_rx
  import i2c_byte_rx_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR  = 7'h2A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic       hostRead,
  input  logic       hostClrIrq,
  input  logic       hostClrOvf,
  output logic [7:0] rxData,
  output logic       rxFull,
  output logic       rxIrq,
  output logic       rxOvf
);

  localparam int DATA_W = ADDR_W + 1;

  logic      sclLvl, sdaLvl, sclRise, sclFall, startCond, stopCond;
  logic      addrHit;
  rxStrobe_t strb;

  i2c_byte_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond)
  );

  i2c_byte_rx_ctrl #(.BYTE_BITS(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startCond(startCond), .stopCond(stopCond), .addrHit(addrHit),
    .bufFull(rxFull), .strb(strb), .sdaLow(sdaDriveLow)
  );

  i2c_byte_rx_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLAVE_ADDR(SLAVE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .strb(strb),
    .hostRead(hostRead), .hostClrIrq(hostClrIrq), .hostClrOvf(hostClrOvf),
    .addrHit(addrHit), .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq), .rxOvf(rxOvf)
  );

endmodule

// File: rtl/i2c_byte_rx_chk.sv
module i2c_byte_rx_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclLvl,
  input logic       loadBuf,
  input logic       sdaDriveLow,
  input logic       hostRead,
  input logic       hostClrOvf,
  input logic [7:0] rxData,
  input logic       rxFull,
  input logic       rxIrq,
  input logic       rxOvf
);

  // R5: acknowledge drive only changes while SCL is low
  p_ack_scl_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sclLvl && $past(sclLvl)) |-> $stable(sdaDriveLow));

  // R6: the overflowing byte is never acknowledged
  p_no_ack_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOvf) |-> !sdaDriveLow);

  // R6: an unread buffer is never overwritten
  p_buf_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxFull && !hostRead) |=> $stable(rxData));

  // R7: overflow is sticky until its own clear
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxOvf && !hostClrOvf) |=> rxOvf);

  // R7: a read with no simultaneous load empties the buffer
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (hostRead && !loadBuf) |=> !rxFull);

  // R4: every load raises the interrupt flag
  p_irq_on_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> rxIrq);

endmodule

bind i2c_byte_rx i2c_byte_rx_chk u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .loadBuf(strb.loadBuf),
  .sdaDriveLow(sdaDriveLow), .hostRead(hostRead), .hostClrOvf(hostClrOvf),
  .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq), .rxOvf(rxOvf)
);

// File: tb/i2c_byte_rx_test.sv
`timescale 1ns/1ps
module i2c_byte_rx_test;

  localparam logic [6:0] MY_ADDR = 7'h2A;
  localparam int Q = 5;
  localparam int H = 10;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic hostRead = 1'b0, hostClrIrq = 1'b0, hostClrOvf = 1'b0;
  logic sdaDriveLow, rxFull, rxIrq, rxOvf;
  logic [7:0] rxData;
  logic sdaLine;

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_byte_rx #(.SLAVE_ADDR(MY_ADDR)) uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .hostRead(hostRead), .hostClrIrq(hostClrIrq),
    .hostClrOvf(hostClrOvf), .rxData(rxData), .rxFull(rxFull), .rxIrq(rxIrq),
    .rxOvf(rxOvf)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] lastLoaded = 8'h00;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; step(Q); sclM = 1'b1; step(H);
    sdaM = 1'b0; step(H); sclM = 1'b0; step(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; step(Q); sclM = 1'b1; step(H); sdaM = 1'b1; step(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; step(Q); sclM = 1'b1; step(H); sclM = 1'b0; step(Q);
    end
    sdaM = 1'b1; step(Q); sclM = 1'b1; step(H/2);
    acked = sdaDriveLow;
    step(H/2); sclM = 1'b0; step(Q);
  endtask

  task automatic pulse(input int which);
    if (which == 0) hostRead = 1'b1;
    else if (which == 1) hostClrIrq = 1'b1;
    else hostClrOvf = 1'b1;
    step(1);
    hostRead = 1'b0; hostClrIrq = 1'b0; hostClrOvf = 1'b0;
    step(1);
  endtask

  task automatic runAll();
    logic ack;
    logic [7:0] addrByte;
    addrByte = {MY_ADDR, 1'b0};
    // R1 reset state
    step(3);
    check(rxData == 8'h00 && !rxFull && !rxIrq && !rxOvf, "R1", "flags/data",
          {rxData, rxFull, rxIrq, rxOvf}, 0);
    check(!sdaDriveLow, "R1", "sda drive", sdaDriveLow, 0);
    rstN = 1'b1;
    step(4);

    // R2/R3 address sweep
    for (int a = 0; a < 256; a++) begin
      logic expHit;
      expHit = (a[7:1] == MY_ADDR) && !a[0];
      busStart();
      sendByte(8'(a), ack);
      check(ack == expHit, expHit ? "R2" : "R3", "address ack", ack, expHit);
      check(!sdaDriveLow, "R5", "release after slot", sdaDriveLow, 0);
      if (expHit) begin
        lastLoaded = 8'(a);
        check(rxData == 8'(a) && rxFull && rxIrq, "R2", "address load",
              {rxData, rxFull, rxIrq}, {a[7:0], 2'b11});
      end else begin
        check(rxData == lastLoaded && !rxFull && !rxIrq, "R3", "no change",
              {rxData, rxFull, rxIrq}, {lastLoaded, 2'b00});
        if (a % 16 == 3) begin
          sendByte(8'h00, ack);
          check(!ack && !rxIrq && rxData == lastLoaded, "R3", "ignored follow byte",
                {ack, rxIrq}, 0);
        end
      end
      busStop();
      pulse(0); pulse(1);
      check(!rxFull && !rxIrq, "R7", "read/clear irq", {rxFull, rxIrq}, 0);
    end

    // R4 data sweep in one transfer
    busStart();
    sendByte(addrByte, ack);
    check(ack, "R2", "own address", ack, 1);
    pulse(0); pulse(1);
    for (int d = 0; d < 256; d++) begin
      sendByte(8'(d), ack);
      check(ack, "R4", "data ack", ack, 1);
      check(rxData == 8'(d) && rxFull && rxIrq, "R4", "data load",
            {rxData, rxFull, rxIrq}, {d[7:0], 2'b11});
      pulse(0); pulse(1);
    end
    busStop();

    // R6/R7 overflow while address byte unread
    busStart();
    sendByte(addrByte, ack);
    check(ack && rxFull, "R2", "address before overflow", {ack, rxFull}, 3);
    pulse(1);
    sendByte(8'hA5, ack);
    check(!ack, "R6", "overflow not acked", ack, 0);
    check(rxOvf && rxIrq && rxData == addrByte, "R6", "overflow flags/buffer",
          {rxData, rxOvf, rxIrq}, {addrByte, 2'b11});
    pulse(1);
    sendByte(8'h3C, ack);
    check(!ack && !rxIrq && rxData == addrByte, "R6", "ignored after overflow",
          {ack, rxIrq, rxData}, {2'b00, addrByte});
    busStop();
    pulse(0);
    check(!rxFull && rxOvf, "R7", "read keeps overflow", {rxFull, rxOvf}, 1);
    pulse(0);
    check(rxOvf, "R7", "overflow sticky", rxOvf, 1);
    pulse(2);
    check(!rxOvf, "R7", "overflow clear", rxOvf, 0);

    // R8 repeated start and stop
    busStart();
    sendByte(addrByte, ack);
    pulse(0); pulse(1);
    sendByte(8'h11, ack);
    check(ack && rxData == 8'h11, "R8", "first data", {ack, rxData}, {1'b1, 8'h11});
    pulse(0); pulse(1);
    sdaM = 1'b1; step(Q);
    busStart();
    sendByte(addrByte, ack);
    check(ack && rxData == addrByte, "R8", "repeated start address",
          {ack, rxData}, {1'b1, addrByte});
    pulse(0); pulse(1);
    sendByte(8'h22, ack);
    check(ack && rxData == 8'h22, "R8", "second data", {ack, rxData}, {1'b1, 8'h22});
    pulse(0); pulse(1);
    busStop();
    sclM = 1'b0; step(Q);
    sendByte(addrByte, ack);
    check(!ack && !rxIrq && rxData == 8'h22, "R8", "idle after stop",
          {ack, rxIrq, rxData}, {2'b00, 8'h22});
    busStop();
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule